// File: doc/BRIEF.md
# Table-Driven ARINC Word Scheduler

This block builds 32-bit ARINC 429 words for one transmit channel by walking a descriptor table held in a byte-wide RAM. Each descriptor is two bytes: an action byte and a value byte. The top three bits of the action byte are an opcode. The opcode either ends the pass, abandons the word being built, places the value byte into the word, or fetches a byte from received-data memory. Received-data memory is addressed by a channel, a label and a byte select. Four placed bytes make one word. The word is offered to the transmitter with a valid strobe and held there until the transmitter acknowledges it.

A repetition-rate counter sets the pace. It counts from 0 up to the configured period value and then rolls over. Every rollover that finds the sequencer idle starts a new pass from the table base address. When a pass is still running at a rollover, a skip bit chooses what follows. With skip set, the next pass waits for a later rollover. With skip clear, the next pass starts as soon as the current one ends. A master transmit enable holds the whole block in its reset state, and a run input gates the counter and the starting of passes.

Top module: `arinc_word_sched`

## Requirements
- R1: While `rst_n` is low, or one cycle after `tx_en` is sampled low, `word_valid` and `mem_rd` are 0 and no pass is in progress.
- R2: With `run` high, the counter rolls over every `cfg_period`+1 cycles. A rollover while idle starts a pass, so passes shorter than the period begin exactly `cfg_period`+1 cycles apart.
- R3: Every pass starts by reading the table base `cfg_base`. Descriptor k is read as action at `cfg_base`+2k and value at `cfg_base`+2k+1, each read returning data on `mem_rdata` one cycle after `mem_rd`.
- R4: Opcode 010 (action bits [7:5]) puts the value byte into the current byte position. Positions fill from bits [7:0] up to bits [31:24].
- R5: Opcodes 011 to 111 read received-data memory at `RX_BASE` + {action[4:2] channel, value byte as label, action[1:0] byte select}, a 13-bit offset, and put the returned byte into the current position.
- R6: Opcode 001 discards the partly built word. The next placed byte goes to bits [7:0].
- R7: Opcode 000 ends the pass. A partly built word is dropped and never presented.
- R8: A completed word is presented with `word_valid` high. `word_data` stays stable and no memory read is made until `word_ack` is seen. The word is consumed at the clock edge where `word_valid` and `word_ack` are both high.
- R9: With `cfg_skip`=1, a pass that overruns its period starts its successor on the next rollover after it ends, so starts stay whole multiples of `cfg_period`+1 apart.
- R10: With `cfg_skip`=0, a rollover during a pass makes the next pass start immediately. Its base read comes 3 cycles after the read of the ending descriptor's value byte.
- R11: While `run` is low, no new pass starts and pending restarts are cleared. A pass already running still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Master transmit enable; low holds the reset state |
| run | input | 1 | Run/stop for the repetition counter and pass starts |
| cfg_skip | input | 1 | Skip-until-rollover select on overrun |
| cfg_period | input | PW | Repetition period minus one, in cycles |
| cfg_base | input | AW | Descriptor table base address |
| mem_rd | output | 1 | RAM read strobe |
| mem_addr | output | AW | RAM read address |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the strobe |
| word_valid | output | 1 | Assembled word available |
| word_data | output | 32 | Assembled ARINC word |
| word_ack | input | 1 | Transmitter takes the word |

## Verification
An immediate descriptor takes three cycles: action read, value read, then decode. A receive-fetch descriptor takes one more cycle for the data read. A word therefore becomes valid the cycle after its fourth byte is placed, and a pass's first base read comes one cycle after the starting rollover. The bench drives inputs and samples on the falling edge and timestamps every base read and end-descriptor read. It checks pass spacing as exact differences of those stamps (period+1, twice that with skip, or 3 cycles after the end read without it). Words are compared in order against a bench model that walks the same table.

// File: rtl/arinc_word_sched.sv
module arinc_word_sched #(
  parameter int AW = 16,
  parameter int PW = 16,
  parameter logic [AW-1:0] RX_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          run,
  input  logic          cfg_skip,
  input  logic [PW-1:0] cfg_period,
  input  logic [AW-1:0] cfg_base,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata,
  output logic          word_valid,
  output logic [31:0]   word_data,
  input  logic          word_ack
);
  localparam int RXW = 13;
  localparam logic [2:0] OP_END = 3'd0;
  localparam logic [2:0] OP_NOP = 3'd1;
  localparam logic [2:0] OP_IMM = 3'd2;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_RV, S_DEC, S_RX, S_HOLD} st_t;

  st_t           st;
  logic [PW-1:0] cnt;
  logic          pend;
  logic [AW-1:0] ptr;
  logic [7:0]    act;
  logic [1:0]    pos;
  logic [31:0]   word;

  wire [2:0] op    = act[7:5];
  wire       roll  = run && (cnt == cfg_period);
  wire       busy  = (st != S_IDLE);
  wire       start = !busy && run && (roll || pend);
  wire       put   = (st == S_DEC && op == OP_IMM) || (st == S_RX);
  wire [RXW-1:0] rx_off = {act[4:2], mem_rdata, act[1:0]};
  wire [AW-1:0]  rx_addr = RX_BASE + AW'(rx_off);

  assign mem_rd = (st == S_RA) || (st == S_RV) ||
                  (st == S_DEC && op != OP_END && op != OP_NOP && op != OP_IMM);
  always_comb begin
    case (st)
      S_RV:    mem_addr = ptr + AW'(1);
      S_DEC:   mem_addr = rx_addr;
      default: mem_addr = ptr;
    endcase
  end
  assign word_data = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pend <= 1'b0; ptr <= '0;
      act <= '0; pos <= '0; word <= '0; word_valid <= 1'b0;
    end else if (!tx_en) begin
      st <= S_IDLE; cnt <= '0; pend <= 1'b0; ptr <= '0;
      act <= '0; pos <= '0; word <= '0; word_valid <= 1'b0;
    end else begin
      cnt <= (!run || roll) ? '0 : cnt + PW'(1);
      if (!run)                         pend <= 1'b0;
      else if (busy && roll && !cfg_skip) pend <= 1'b1;
      else if (start)                   pend <= 1'b0;

      if (put) begin
        word[{pos, 3'b000} +: 8] <= mem_rdata;
        ptr <= ptr + AW'(2);
        if (pos == 2'd3) begin
          word_valid <= 1'b1;
          st <= S_HOLD;
        end else begin
          pos <= pos + 2'd1;
          st <= S_RA;
        end
      end else begin
        case (st)
          S_IDLE: if (start) begin
            ptr <= cfg_base;
            pos <= '0;
            st  <= S_RA;
          end
          S_RA: st <= S_RV;
          S_RV: begin
            act <= mem_rdata;
            st  <= S_DEC;
          end
          S_DEC: begin
            if (op == OP_END) st <= S_IDLE;
            else if (op == OP_NOP) begin
              pos <= '0;
              ptr <= ptr + AW'(2);
              st  <= S_RA;
            end else st <= S_RX;
          end
          S_HOLD: if (word_ack) begin
            word_valid <= 1'b0;
            pos <= '0;
            st  <= S_RA;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r1_off_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!word_valid && !mem_rd && st == S_IDLE));

  a_r3_pass_from_base: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && start) |=> (mem_rd && mem_addr == $past(cfg_base)));

  a_r7_end_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && st == S_DEC && op == OP_END) |=> (!busy && !word_valid));

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && word_valid && !word_ack) |=> (word_valid && $stable(word_data)));

  a_r8_no_read_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !mem_rd);

  a_r9_skip_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && cfg_skip && !pend) |=> !pend);
endmodule

// File: tb/tb_arinc_word_sched.sv
module tb_arinc_word_sched;
  logic clk = 0, rst_n = 0, tx_en = 0, run = 0, cfg_skip = 0, word_ack = 0;
  logic [15:0] cfg_period = 16'd40, cfg_base = 16'h2000;
  logic mem_rd, word_valid;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata;
  logic [31:0] word_data;

  always #10 clk = ~clk;

  arinc_word_sched dut (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .run(run),
    .cfg_skip(cfg_skip), .cfg_period(cfg_period), .cfg_base(cfg_base),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .word_valid(word_valid), .word_data(word_data), .word_ack(word_ack));

  logic [7:0] mem [0:16383];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[13:0]];

  int tests = 0, fails = 0, cyc = 0, hold_cnt = 0, ack_delay = 0;
  int cur_base = 0, cur_endv = -1;
  logic mon_on = 0;
  logic [31:0] got_q[$], exp_q[$];
  int starts[$], endvs[$];
  logic [31:0] last_w;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (mon_on) begin
      if (mem_rd && mem_addr == 16'(cur_base)) starts.push_back(cyc);
      if (mem_rd && int'(mem_addr) == cur_endv) endvs.push_back(cyc);
      if (word_valid && mem_rd) chk(0, "R8 read during hold", 1, 0);
      if (word_ack) word_ack = 0;
      else if (word_valid) begin
        if (hold_cnt > 0 && word_data != last_w) chk(0, "R8 word changed while held", word_data, last_w);
        last_w = word_data;
        if (hold_cnt >= ack_delay) begin
          got_q.push_back(word_data);
          word_ack = 1; hold_cnt = 0;
        end else hold_cnt++;
      end
    end
  end

  function automatic void model(input int base);
    int p = 0;
    logic [31:0] w = 0;
    exp_q.delete();
    for (int k = 0; k < 200; k++) begin
      logic [7:0] a, v, b;
      bit pl;
      a = mem[base + 2*k]; v = mem[base + 2*k + 1]; pl = 0; b = 0;
      if (a[7:5] == 3'd0) break;
      else if (a[7:5] == 3'd1) p = 0;
      else if (a[7:5] == 3'd2) begin b = v; pl = 1; end
      else begin b = mem[{1'b0, a[4:2], v, a[1:0]}]; pl = 1; end
      if (pl) begin
        w[p*8 +: 8] = b;
        if (p == 3) begin exp_q.push_back(w); p = 0; end else p++;
      end
    end
  endfunction

  task automatic wd(input int base, input int k, input logic [7:0] a, input logic [7:0] v);
    mem[base + 2*k] = a; mem[base + 2*k + 1] = v;
  endtask

  task automatic run_case(input string tag, input int base, input int per, input bit skip,
                          input int ad, input int ncyc, input int endv);
    model(base);
    got_q.delete(); starts.delete(); endvs.delete();
    cur_base = base; cur_endv = endv; ack_delay = ad; hold_cnt = 0;
    cfg_base = 16'(base); cfg_period = 16'(per); cfg_skip = skip;
    mon_on = 1; run = 1;
    repeat (ncyc) @(negedge clk);
    run = 0;
    repeat (300) @(negedge clk);
    chk(starts.size() > 0, {tag, " R2 passes started"}, starts.size(), 1);
    chk(got_q.size() == starts.size() * exp_q.size(), {tag, " R3 word count"},
        got_q.size(), starts.size() * exp_q.size());
    for (int i = 0; i < got_q.size() && exp_q.size() > 0; i++)
      if (got_q[i] != exp_q[i % exp_q.size()]) begin
        chk(0, {tag, " word mismatch"}, got_q[i], exp_q[i % exp_q.size()]);
        break;
      end
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16384; i++) mem[i] = 8'($urandom());
    repeat (3) @(negedge clk);
    chk(!word_valid && !mem_rd, "R1 reset state", {word_valid, mem_rd}, 0);
    rst_n = 1; tx_en = 1;
    repeat (3) @(negedge clk);
    chk(!word_valid && !mem_rd, "R11 idle while run low", {word_valid, mem_rd}, 0);

    // R4: immediates fill bytes LSB first
    wd(16'h2000, 0, 8'h40, 8'h11); wd(16'h2000, 1, 8'h40, 8'h22);
    wd(16'h2000, 2, 8'h40, 8'h33); wd(16'h2000, 3, 8'h40, 8'h44);
    wd(16'h2000, 4, 8'h00, 8'h00);
    model(16'h2000);
    chk(exp_q.size() == 1 && exp_q[0] == 32'h44332211, "R4 model word", exp_q[0], 32'h44332211);
    run_case("R4", 16'h2000, 40, 0, 0, 200, -1);
    chk(got_q.size() > 0 && got_q[0] == 32'h44332211, "R4 immediate word", got_q[0], 32'h44332211);
    for (int i = 1; i < starts.size(); i++)
      chk(starts[i] - starts[i-1] == 41, "R2 pass spacing", starts[i] - starts[i-1], 41);

    // R6 no-op drops partial; R7 end drops partial
    wd(16'h2100, 0, 8'h40, 8'hAA); wd(16'h2100, 1, 8'h20, 8'h00);
    wd(16'h2100, 2, 8'h40, 8'h01); wd(16'h2100, 3, 8'h40, 8'h02);
    wd(16'h2100, 4, 8'h40, 8'h03); wd(16'h2100, 5, 8'h40, 8'h04);
    wd(16'h2100, 6, 8'h40, 8'h55); wd(16'h2100, 7, 8'h00, 8'h00);
    run_case("R6", 16'h2100, 50, 0, 1, 160, -1);
    chk(got_q.size() > 0 && got_q[0] == 32'h04030201, "R6 no-op discards partial", got_q[0], 32'h04030201);
    chk(got_q.size() == starts.size(), "R7 end drops partial word", got_q.size(), starts.size());

    // R5 receive-memory fetch
    wd(16'h2200, 0, {3'd3, 3'd5, 2'd0}, 8'h12); wd(16'h2200, 1, {3'd7, 3'd0, 2'd3}, 8'hFF);
    wd(16'h2200, 2, {3'd4, 3'd7, 2'd2}, 8'h00); wd(16'h2200, 3, {3'd5, 3'd2, 2'd1}, 8'h80);
    wd(16'h2200, 4, 8'h00, 8'h00);
    begin
      logic [31:0] e;
      e = {mem[{1'b0, 3'd2, 8'h80, 2'd1}], mem[{1'b0, 3'd7, 8'h00, 2'd2}],
           mem[{1'b0, 3'd0, 8'hFF, 2'd3}], mem[{1'b0, 3'd5, 8'h12, 2'd0}]};
      run_case("R5", 16'h2200, 30, 0, 2, 100, -1);
      chk(got_q.size() > 0 && got_q[0] == e, "R5 receive fetch word", got_q[0], e);
    end

    // R9 skip on overrun: one word, long hold
    wd(16'h2300, 0, 8'h40, 8'hA1); wd(16'h2300, 1, 8'h40, 8'hB2);
    wd(16'h2300, 2, 8'h40, 8'hC3); wd(16'h2300, 3, 8'h40, 8'hD4);
    wd(16'h2300, 4, 8'h00, 8'h00);
    run_case("R9", 16'h2300, 20, 1, 15, 300, 16'h2300 + 9);
    for (int i = 1; i < starts.size(); i++)
      chk(starts[i] - starts[i-1] == 42, "R9 skip waits next rollover", starts[i] - starts[i-1], 42);
    // R10 no skip: restart right after end
    run_case("R10", 16'h2300, 20, 0, 15, 300, 16'h2300 + 9);
    chk(starts.size() >= 3, "R10 passes", starts.size(), 3);
    for (int i = 1; i < starts.size() && i <= endvs.size(); i++)
      chk(starts[i] - endvs[i-1] == 3, "R10 immediate restart", starts[i] - endvs[i-1], 3);

    // R11 run low: no passes
    cur_base = 16'h2300; starts.delete(); mon_on = 1; cfg_period = 16'd5;
    repeat (100) @(negedge clk);
    chk(starts.size() == 0, "R11 no pass while run low", starts.size(), 0);
    mon_on = 0;

    // random tables
    for (int t = 0; t < 8; t++) begin
      int base, nw, k;
      base = 16'h2400 + t * 16'h80; k = 0;
      nw = 1 + int'($urandom_range(0, 2));
      for (int w = 0; w < nw; w++) begin
        if ($urandom_range(0, 3) == 0) begin
          wd(base, k, 8'h40, 8'($urandom())); k++;
          wd(base, k, 8'h20, 8'h00); k++;
        end
        for (int b = 0; b < 4; b++) begin
          logic [2:0] op;
          op = 3'($urandom_range(2, 7));
          wd(base, k, {op, 5'($urandom())}, 8'($urandom())); k++;
        end
      end
      wd(base, k, 8'h00, 8'h00);
      run_case($sformatf("R3/R5 random%0d", t), base, 40 + int'($urandom_range(0, 40)),
               1'($urandom()), int'($urandom_range(0, 3)), 400, -1);
    end

    // R1 enable drop mid-pass
    cur_base = 16'h2300; cfg_base = 16'h2300; cfg_period = 16'd10; ack_delay = 100;
    mon_on = 1; run = 1;
    repeat (30) @(negedge clk);
    tx_en = 0; word_ack = 0; mon_on = 0;
    @(negedge clk);
    begin
      bit bad = 0;
      repeat (30) begin
        if (word_valid || mem_rd) bad = 1;
        @(negedge clk);
      end
      chk(!bad, "R1 held in reset while disabled", bad, 0);
    end
    run = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule